// File: doc/BRIEF.md
# Prescaled PWM Timer with Buffered Reload and Compare

This block is an up-counting pulse-width timer for one output channel. A divider stretches the input clock by a programmable factor. The divided ticks step a counter from zero up to a reload limit, and then the counter returns to zero. The output is high while the count is below a compare threshold. The output is therefore a rectangular wave. Its period is set by the divider and the reload limit, and its high time is set by the compare threshold.

Software reaches the block through a single write port. Each write carries a selector and a data word. The reload and compare values each have their own buffering switch. With the switch off, a write to that value takes effect in the next cycle. With the switch on, the write is parked in a shadow copy and moves to the active copy when the counter rolls over. A running period is therefore never cut short or stretched by a change to its own limits. The divider value is always parked in the same way while the timer runs. A channel-enable bit decides whether the compare result reaches the pin. A one-cycle marker reports each rollover.

Top module: `pwm_timer`

## Requirements
- R1: After reset, `pwm_out`, `upd_pulse` and `cnt_val` are all zero. The timer is stopped, both buffering switches are off, the channel is disabled, the divider value is 0 and the compare value is 0.
- R2: While running, the counter advances by one every (P+1) clocks, where P is the active divider value. It goes from 0 up to the active reload value R, and then returns to 0. One period therefore lasts (P+1)·(R+1) clocks.
- R3: With the channel enabled, `pwm_out` is high exactly while the count is strictly below the active compare value C. Over one period this gives min(C, R+1)·(P+1) high clocks. C = 0 keeps the output low, and any C > R keeps it high for the whole period.
- R4: With channel enable (control bit 3) clear, `pwm_out` stays low while the counter keeps running.
- R5: With reload buffering (control bit 1) clear, a reload write while running becomes active in the next cycle. If the count is already above the new value, counting continues up to the all-ones count (0xFFFF at the default width), then returns to 0.
- R6: With reload buffering set, a reload write while running leaves the current period unchanged. The new value governs the period that starts at the next rollover.
- R7: The compare value behaves in the same way under its own buffering switch (control bit 2). When the switch is clear, the new value changes the output in the current period. When it is set, the new value waits for the next rollover.
- R8: A divider write while running does not alter the current period. It takes effect from the next rollover.
- R9: `upd_pulse` is high for one cycle, in the first cycle after each rollover, that is, the cycle in which the count is 0.
- R10: Writes are selected by `wr_sel`: 0 is the divider, 1 is reload, 2 is compare and 3 is control. The control bits are run (bit 0), reload buffering (bit 1), compare buffering (bit 2) and channel enable (bit 3). While run is clear, the counter and the divider phase are held at zero, and writes to all three values become active in the next cycle. Setting run starts the first period at count 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Target of the write (0 divider, 1 reload, 2 compare, 3 control) |
| wr_data | input | CNT_W | Write data |
| pwm_out | output | 1 | Gated pulse-width output |
| upd_pulse | output | 1 | One-cycle rollover marker |
| cnt_val | output | CNT_W | Current count |

## Verification
A write presented before a rising edge is captured at that edge. The count, the output and the rollover marker all read from registers, so they change at that same edge and are sampled at the following falling edge. Setting run puts count 0 on the outputs at the first falling edge after the write. From that sample on, the bench walks period by period, one falling edge per clock. It totals the high samples, the largest count and the number of clocks until the sample in which `upd_pulse` is seen. Mid-period writes are issued at the falling edge where a chosen count is visible. The new value therefore lands one tick later, and the remainder of the period is checked from the next sample.

// File: rtl/pwm_timer.sv
`timescale 1ns/1ps
module pwm_timer #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic             pwm_out,
  output logic             upd_pulse,
  output logic [CNT_W-1:0] cnt_val
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;
  localparam logic [1:0] SEL_PSC = 2'd0;
  localparam logic [1:0] SEL_RLD = 2'd1;
  localparam logic [1:0] SEL_CMP = 2'd2;
  localparam logic [1:0] SEL_CTL = 2'd3;

  logic             run, rld_pre, cmp_pre, ch_en;
  logic [PSC_W-1:0] psc_act, psc_sh, pdiv;
  logic [CNT_W-1:0] arr_act, arr_sh, ccr_act, ccr_sh, cnt;
  logic             upd_q;

  wire wr_psc = wr_en && (wr_sel == SEL_PSC);
  wire wr_rld = wr_en && (wr_sel == SEL_RLD);
  wire wr_cmp = wr_en && (wr_sel == SEL_CMP);
  wire wr_ctl = wr_en && (wr_sel == SEL_CTL);

  wire tick = run && (pdiv == psc_act);
  wire wrap = tick && ((cnt == arr_act) || (cnt == CNT_TOP));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run     <= 1'b0;
      rld_pre <= 1'b0;
      cmp_pre <= 1'b0;
      ch_en   <= 1'b0;
    end else if (wr_ctl) begin
      {ch_en, cmp_pre, rld_pre, run} <= wr_data[3:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run)
      pdiv <= '0;
    else if (tick)
      pdiv <= '0;
    else
      pdiv <= pdiv + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run)
      cnt <= '0;
    else if (wrap)
      cnt <= '0;
    else if (tick)
      cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psc_sh  <= '0;
      psc_act <= '0;
    end else begin
      if (wr_psc)
        psc_sh <= wr_data[PSC_W-1:0];
      if (wr_psc && !run)
        psc_act <= wr_data[PSC_W-1:0];
      else if (wrap)
        psc_act <= psc_sh;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arr_sh  <= CNT_TOP;
      arr_act <= CNT_TOP;
    end else begin
      if (wr_rld)
        arr_sh <= wr_data;
      if (wr_rld && (!run || !rld_pre))
        arr_act <= wr_data;
      else if (wrap)
        arr_act <= arr_sh;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ccr_sh  <= '0;
      ccr_act <= '0;
    end else begin
      if (wr_cmp)
        ccr_sh <= wr_data;
      if (wr_cmp && (!run || !cmp_pre))
        ccr_act <= wr_data;
      else if (wrap)
        ccr_act <= ccr_sh;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      upd_q <= 1'b0;
    else
      upd_q <= wrap;
  end

  assign pwm_out   = ch_en && (cnt < ccr_act);
  assign upd_pulse = upd_q;
  assign cnt_val   = cnt;

endmodule

// File: rtl/pwm_timer_chk.sv
`timescale 1ns/1ps
module pwm_timer_chk #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             rld_pre,
  input logic             cmp_pre,
  input logic             wrap,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] arr_act,
  input logic [CNT_W-1:0] ccr_act,
  input logic [PSC_W-1:0] psc_act,
  input logic             upd_pulse
);

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> ((cnt == '0) || (cnt == $past(cnt) + 1'b1)))
    else $error("counter jumped");

  a_r10_stopped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && $past(!run)) |-> (cnt == '0))
    else $error("counter moved while stopped");

  a_r6_rld_buffered: assert property (@(posedge clk) disable iff (!rst_n)
    (run && rld_pre && !wrap) |=> $stable(arr_act))
    else $error("buffered reload changed mid-period");

  a_r7_cmp_buffered: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cmp_pre && !wrap) |=> $stable(ccr_act))
    else $error("buffered compare changed mid-period");

  a_r8_psc_buffered: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> $stable(psc_act))
    else $error("divider changed mid-period");

  a_r9_upd_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse |-> (cnt == '0))
    else $error("update marker away from count zero");

endmodule

bind pwm_timer pwm_timer_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .rld_pre(rld_pre), .cmp_pre(cmp_pre),
  .wrap(wrap), .cnt(cnt), .arr_act(arr_act), .ccr_act(ccr_act),
  .psc_act(psc_act), .upd_pulse(upd_pulse)
);

// File: tb/pwm_timer_bench.sv
`timescale 1ns/1ps
module pwm_timer_bench;
  localparam int CNT_W = 16;
  localparam int NVEC  = 6;
  localparam int LIMIT = 70000;

  typedef struct packed {
    logic [15:0] psc;
    logic [15:0] arr;
    logic [15:0] ccr;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{psc: 16'd0, arr: 16'd9,  ccr: 16'd3},
    '{psc: 16'd1, arr: 16'd4,  ccr: 16'd2},
    '{psc: 16'd2, arr: 16'd3,  ccr: 16'd0},
    '{psc: 16'd0, arr: 16'd5,  ccr: 16'd9},
    '{psc: 16'd3, arr: 16'd7,  ccr: 16'd8},
    '{psc: 16'd0, arr: 16'd15, ccr: 16'd15}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_sel = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic             pwm_out, upd_pulse;
  logic [CNT_W-1:0] cnt_val;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  pwm_timer #(.CNT_W(CNT_W), .PSC_W(16)) u_pwm_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pwm_out(pwm_out), .upd_pulse(upd_pulse), .cnt_val(cnt_val)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input int data);
    wr_en   = 1'b1;
    wr_sel  = sel;
    wr_data = data[CNT_W-1:0];
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic stats(output int n, output int highs, output int maxv);
    n = 0; highs = 0; maxv = 0;
    for (int i = 0; i < LIMIT; i++) begin
      if (pwm_out) highs++;
      if (int'(cnt_val) > maxv) maxv = int'(cnt_val);
      n++;
      @(negedge clk);
      if (upd_pulse) break;
    end
  endtask

  task automatic wait_cnt(input int v);
    for (int i = 0; i < LIMIT; i++) begin
      if (int'(cnt_val) == v) break;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int n, hi, mx, ehi, pl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pwm_out", int'(pwm_out), 0);
    chk("R1 upd_pulse", int'(upd_pulse), 0);
    chk("R1 cnt_val", int'(cnt_val), 0);
    repeat (3) @(negedge clk);
    chk("R10 counter idle while stopped", int'(cnt_val), 0);

    for (int k = 0; k < NVEC; k++) begin
      wr(2'd3, 0);
      wr(2'd0, int'(VECS[k].psc));
      wr(2'd1, int'(VECS[k].arr));
      wr(2'd2, int'(VECS[k].ccr));
      wr(2'd3, 9);
      pl  = (int'(VECS[k].psc) + 1) * (int'(VECS[k].arr) + 1);
      ehi = (VECS[k].ccr > VECS[k].arr) ? int'(VECS[k].arr) + 1 : int'(VECS[k].ccr);
      ehi = ehi * (int'(VECS[k].psc) + 1);
      chk("R10 run starts at zero", int'(cnt_val), 0);
      stats(n, hi, mx);
      chk("R2 first period length", n, pl);
      chk("R2 peak count", mx, int'(VECS[k].arr));
      chk("R3 high clocks", hi, ehi);
      stats(n, hi, mx);
      chk("R9 marker spacing", n, pl);
      chk("R3 high clocks second period", hi, ehi);
      @(negedge clk);
      chk("R9 marker lasts one cycle", int'(upd_pulse), 0);
    end

    wr(2'd3, 0);
    wr(2'd0, 0); wr(2'd1, 9); wr(2'd2, 5);
    wr(2'd3, 1);
    stats(n, hi, mx);
    chk("R4 output gated", hi, 0);
    chk("R4 counter still runs", mx, 9);

    wr(2'd3, 0);
    wr(2'd1, 9); wr(2'd2, 0);
    wr(2'd3, 3);
    wait_cnt(3);
    wr(2'd1, 4);
    stats(n, hi, mx);
    chk("R6 current period keeps old reload", mx, 9);
    stats(n, hi, mx);
    chk("R6 next period uses new reload", n, 5);

    wr(2'd3, 0);
    wr(2'd1, 9);
    wr(2'd3, 1);
    wait_cnt(6);
    wr(2'd1, 4);
    stats(n, hi, mx);
    chk("R5 overshoot runs to all-ones", mx, 65535);
    chk("R5 overshoot length", n, 65536 - 7);
    stats(n, hi, mx);
    chk("R5 new reload active", n, 5);

    wr(2'd3, 0);
    wr(2'd1, 9); wr(2'd2, 2);
    wr(2'd3, 13);
    wait_cnt(5);
    wr(2'd2, 8);
    stats(n, hi, mx);
    chk("R7 buffered compare waits", hi, 0);
    stats(n, hi, mx);
    chk("R7 buffered compare applied", hi, 8);

    wr(2'd3, 0);
    wr(2'd1, 9); wr(2'd2, 2);
    wr(2'd3, 9);
    wait_cnt(5);
    wr(2'd2, 8);
    stats(n, hi, mx);
    chk("R7 direct compare immediate", hi, 2);

    wr(2'd3, 0);
    wr(2'd0, 0); wr(2'd1, 9);
    wr(2'd3, 1);
    wait_cnt(2);
    wr(2'd0, 1);
    stats(n, hi, mx);
    chk("R8 current period unchanged", n, 7);
    stats(n, hi, mx);
    chk("R8 divider applied after rollover", n, 20);

    finish_run();
  end
endmodule